// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a counter that advances on a slow tick of about 1.024 kHz. The tick arrives as a single-cycle enable that is synchronous to the system clock. Software must clear the counter by pulsing a clear input before the selected period runs out.

An 8-bit mode register, written over a small register bus, sets two things. The low field selects one of eight periods, from 8 to 8192 ticks. A second field selects a window mode. With the window off, the first missed deadline raises a one-cycle interrupt, and a second consecutive miss raises a reset. With a window on, a clear is accepted only in the late part of the period. An early clear causes a reset, and so does any overflow; no interrupt is raised in these modes.

The reset output is a one-cycle pulse. After it, the block returns to its power-up state, and this includes the mode register.

Top module: `wdt_window`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0x06, and both `irq` and `wdt_rst` are low.
- R2: The mode register always reads back in this layout: bits 2:0 hold the period code, bits 5:4 hold the window code, and bits 7, 6 and 3 read as zero.
- R3: Period codes 0 to 7 give P = 8, 16, 32, 64, 128, 512, 2048 and 8192 ticks. With the window off and no clear pending, the P-th tick after the counter was zeroed makes `irq` high for exactly one cycle, in the cycle after that tick's edge. The count then restarts from zero.
- R4: With the window off, an overflow that follows an interrupt with no accepted clear in between makes `wdt_rst` high in the cycle after the overflowing tick.
- R5: An accepted clear sets the count to zero and cancels any pending second-overflow condition.
- R6: When the window is active, an overflow raises `wdt_rst` and never `irq`.
- R7: With window code 01 active, a clear is accepted once the count has reached P/4. With window code 10 or 11 active, it is accepted once the count has reached P/2. A clear before that point raises `wdt_rst` in the next cycle.
- R8: For period codes 0 to 3 the window is inactive whatever bits 5:4 hold, so any clear is accepted.
- R9: A register write whose period code differs from the current one zeroes the count. A write that keeps the same period code leaves the count running.
- R10: `wdt_rst` is high for one cycle only. In the following cycle the block is in its power-up state, with `rd_data` reading 0x06.
- R11: When a clear and the overflowing tick arrive in the same cycle, an accepted clear takes priority, so neither `irq` nor `wdt_rst` rises. A rejected clear still gives `wdt_rst`.
- R12: The count changes only on cycles where `tick` is high. Cycles without a tick can never produce `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick | input | 1 | Single-cycle count enable at about 1.024 kHz |
| clr | input | 1 | Single-cycle clear request from software |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| rd_data | output | 8 | Mode register read value |
| irq | output | 1 | One-cycle watchdog interrupt pulse |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The risky coincidence is a clear request that lands on the same cycle as the tick that would overflow the counter. The bench forces this with directed cases, once with the window off and once with window code 01 active. It also lets it happen by chance under random tick and clear traffic on short periods. In each case the outputs are compared against a bench model that applies the rule that an accepted clear wins: neither output may rise, and the following full period must reach its overflow again.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int CW = 13,
  parameter logic [7:0] MODE_INIT = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       wdt_rst
);
  localparam logic [7:0] RD_MASK = 8'h37;

  logic [7:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q, rst_q, irq_q;
  logic [CW-1:0] last;

  wire [2:0] pc = mode_q[2:0];
  wire [1:0] wm = mode_q[5:4];

  always_comb begin
    case (pc)
      3'd0: last = CW'(7);
      3'd1: last = CW'(15);
      3'd2: last = CW'(31);
      3'd3: last = CW'(63);
      3'd4: last = CW'(127);
      3'd5: last = CW'(511);
      3'd6: last = CW'(2047);
      default: last = CW'(8191);
    endcase
  end

  wire win_on  = pc[2] & (wm != 2'b00);
  wire early   = (wm == 2'b01) ? (cnt_q <= (last >> 2)) : (cnt_q <= (last >> 1));
  wire ovf     = tick & (cnt_q == last);
  wire clr_bad = clr & win_on & early;
  wire clr_ok  = clr & ~clr_bad;
  wire fault   = clr_bad | (ovf & ~clr_ok & (win_on | pend_q));
  wire irq_ev  = ovf & ~clr_ok & ~win_on & ~pend_q;
  wire pc_chg  = wr_en & (wr_data[2:0] != pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (rst_q) begin
      mode_q <= MODE_INIT;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rst_q <= fault;
      irq_q <= irq_ev;
      if (wr_en) mode_q <= wr_data & RD_MASK;
      if (clr_ok || ovf || pc_chg) cnt_q <= '0;
      else if (tick)               cnt_q <= cnt_q + 1'b1;
      if (clr_ok)      pend_q <= 1'b0;
      else if (irq_ev) pend_q <= 1'b1;
    end
  end

  assign rd_data = mode_q;
  assign irq     = irq_q;
  assign wdt_rst = rst_q;
endmodule

module wdt_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       wdt_rst
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:6] == 2'b00) && (rd_data[3] == 1'b0));
  a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_no_irq_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !($past(rd_data[2]) && ($past(rd_data[5:4]) != 2'b00)));
  a_r10_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  a_r10_mode_restored: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (rd_data == 8'h06));
  a_r12_no_tick_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq);
  a_r4_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && wdt_rst));
endmodule

bind wdt_window wdt_window_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_data(rd_data),
  .irq(irq), .wdt_rst(wdt_rst)
);

// File: tb/test_wdt_window.sv
`timescale 1ns/1ps
module test_wdt_window;
  logic clk = 0, rst_n = 0, tick = 0, clr = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq, wdt_rst;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_mode = 6, m_cnt = 0;
  bit m_pend = 0, m_rst = 0, m_irq = 0;

  always #2 clk = ~clk;

  wdt_window i_wdt_window (.clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wdt_rst(wdt_rst));

  function automatic int f_last(int code);
    case (code)
      0: return 7;     1: return 15;   2: return 31;   3: return 63;
      4: return 127;   5: return 511;  6: return 2047; default: return 8191;
    endcase
  endfunction

  function automatic void model(bit t, bit c, bit w, int d);
    int last, wm, newmode;
    bit won, early, ovf, bad, ok, fault, iev, chg;
    if (m_rst) begin
      m_mode = 6; m_cnt = 0; m_pend = 0; m_rst = 0; m_irq = 0;
      return;
    end
    last  = f_last(m_mode & 7);
    wm    = (m_mode >> 4) & 3;
    won   = ((m_mode & 4) != 0) && (wm != 0);
    early = won && (m_cnt < ((wm == 1) ? (last + 1) / 4 : (last + 1) / 2));
    ovf   = t && (m_cnt == last);
    bad   = c && early;
    ok    = c && !bad;
    fault = bad || (ovf && !ok && (won || m_pend));
    iev   = ovf && !ok && !won && !m_pend;
    newmode = w ? (d & 8'h37) : m_mode;
    chg   = w && ((d & 7) != (m_mode & 7));
    if (ok || ovf || chg) m_cnt = 0;
    else if (t) m_cnt = m_cnt + 1;
    if (ok) m_pend = 0;
    else if (iev) m_pend = 1;
    m_rst = fault; m_irq = iev; m_mode = newmode;
  endfunction

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic step(bit t, bit c, bit w, logic [7:0] d);
    tick = t; clr = c; wr_en = w; wr_data = d;
    @(posedge clk); #1;
    model(t, c, w, d);
    tick = 0; clr = 0; wr_en = 0;
    chk({cur_req, " model"}, {rd_data, 6'b0, irq, wdt_rst}, {m_mode[7:0], 6'b0, m_irq, m_rst});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R1 reset mode", rd_data, 8'h06);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset rst", wdt_rst, 0);

    cur_req = "R2";
    step(0, 0, 1, 8'hFF);
    chk("R2 readback", rd_data, 8'h37);

    cur_req = "R3";
    step(0, 0, 1, 8'h00);
    ticks(7);
    chk("R3 no early irq", irq, 0);
    ticks(1);
    chk("R3 irq on 8th tick", irq, 1);
    step(0, 0, 0, 8'h00);
    chk("R3 irq one cycle", irq, 0);

    cur_req = "R4";
    ticks(8);
    chk("R4 second overflow reset", wdt_rst, 1);
    chk("R4 no irq", irq, 0);
    cur_req = "R10";
    step(0, 0, 0, 8'h00);
    chk("R10 rst one cycle", wdt_rst, 0);
    chk("R10 mode restored", rd_data, 8'h06);

    cur_req = "R5";
    step(0, 0, 1, 8'h00);
    ticks(8);
    chk("R5 first irq", irq, 1);
    ticks(4);
    step(0, 1, 0, 8'h00);
    ticks(7);
    chk("R5 count restarted", irq, 0);
    ticks(1);
    chk("R5 pending cancelled irq", irq, 1);
    chk("R5 pending cancelled rst", wdt_rst, 0);
    step(0, 1, 0, 8'h00);

    cur_req = "R8";
    step(0, 0, 1, 8'h33);
    step(0, 1, 0, 8'h00);
    chk("R8 early clear accepted", wdt_rst, 0);
    ticks(64);
    chk("R8 short period irq", irq, 1);

    cur_req = "R7";
    step(0, 0, 1, 8'h14);
    ticks(31);
    step(0, 1, 0, 8'h00);
    chk("R7 mode1 early clear", wdt_rst, 1);
    step(0, 0, 0, 8'h00);
    step(0, 0, 1, 8'h14);
    ticks(32);
    step(0, 1, 0, 8'h00);
    chk("R7 mode1 clear at P/4", wdt_rst, 0);
    cur_req = "R6";
    ticks(128);
    chk("R6 window overflow reset", wdt_rst, 1);
    chk("R6 window no irq", irq, 0);
    step(0, 0, 0, 8'h00);

    cur_req = "R7";
    step(0, 0, 1, 8'h34);
    ticks(63);
    step(0, 1, 0, 8'h00);
    chk("R7 mode3 early clear", wdt_rst, 1);
    step(0, 0, 0, 8'h00);
    step(0, 0, 1, 8'h24);
    ticks(64);
    step(0, 1, 0, 8'h00);
    chk("R7 mode2 clear at P/2", wdt_rst, 0);

    cur_req = "R9";
    step(0, 0, 1, 8'h00);
    ticks(5);
    step(0, 0, 1, 8'h00);
    ticks(3);
    chk("R9 same code keeps count", irq, 1);
    step(0, 1, 0, 8'h00);
    ticks(5);
    step(0, 0, 1, 8'h01);
    ticks(15);
    chk("R9 new code restarts", irq, 0);
    ticks(1);
    chk("R9 new period irq", irq, 1);

    cur_req = "R11";
    step(0, 0, 1, 8'h00);
    step(0, 1, 0, 8'h00);
    ticks(7);
    step(1, 1, 0, 8'h00);
    chk("R11 clear beats overflow irq", irq, 0);
    chk("R11 clear beats overflow rst", wdt_rst, 0);
    ticks(8);
    chk("R11 full period after", irq, 1);
    step(0, 1, 0, 8'h00);
    step(0, 0, 1, 8'h14);
    ticks(127);
    step(1, 1, 0, 8'h00);
    chk("R11 window clear beats overflow", wdt_rst, 0);
    ticks(31);
    step(1, 1, 0, 8'h00);
    chk("R11 rejected clear with tick", wdt_rst, 1);
    step(0, 0, 0, 8'h00);

    cur_req = "R12";
    step(0, 0, 1, 8'h00);
    for (int i = 0; i < 50; i++) step(0, 0, 0, 8'h00);
    chk("R12 idle irq", irq, 0);
    chk("R12 idle rst", wdt_rst, 0);
    ticks(8);
    chk("R12 ticks counted", irq, 1);

    cur_req = "R5 R6 R7 R11 random";
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] d;
      bit t, c, w;
      t = ($urandom % 100) < 45;
      c = ($urandom % 40) == 0;
      w = ($urandom % 300) == 0;
      d = 8'($urandom);
      d[2:0] = 3'($urandom % 6);
      step(t, c, w, d);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule